// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog

This block is a memory-mapped watchdog timer for a system bus. Software arms it, services it and disarms it through two 32-bit control/status words. A free-running timebase counter is also readable, so software can confirm that the block is being clocked. The watchdog interval is 2^INTERVAL_LOG2 clock cycles.

Expiry happens in two stages. The first unserviced interval sets a state flag, and the interrupt output follows that flag. If the flag is still set when the next interval ends, the block drives a reset pulse of RST_W cycles and sets a sticky reset-status flag. Software services the watchdog by writing 1 to the state-flag bit. That write clears the flag and starts a fresh interval.

Two independent enable bits keep the watchdog running, and both must be cleared to stop it. A build option, ENABLE_ONCE, locks the enables on once the watchdog has run. The bus port is a single-cycle write strobe plus a combinational read path selected by the address.

Top module: `dual_stage_wdog`

## Requirements
- R1: After reset, the enables, the state flag, the reset-status flag, `irq` and `wdog_rst` are all 0, and word 0 and word 1 both read as zero.
- R2: The register map is laid out as follows.
  - Word 0 (address 0x0) has reset-status in bit 3, the state flag in bit 2, enable 1 in bit 1 and enable 2 in bit 0.
  - Word 1 (address 0x4) shows enable 2 in bit 0.
  - Address 0x8 returns the timebase.
  - Any other address reads as zero.
  - A write to bit 0 of either word sets or clears enable 2.
- R3: The timebase starts at 0 after reset and increases by one every clock, so two reads one cycle apart differ by exactly 1.
- R4: While running, the state flag and `irq` rise exactly 2^INTERVAL_LOG2 cycles after the write that started the interval.
- R5: If the state flag is still set when the next interval ends, `wdog_rst` is high for exactly RST_W cycles, starting 2^INTERVAL_LOG2 cycles after `irq` rose, and the reset-status flag sets in the same cycle.
- R6: Writing word 0 with bit 2 set clears the state flag, so `irq` is low from the next cycle, and restarts the interval count from zero.
- R7: The reset-status flag stays set through keepalives and through stopping the watchdog. Only a write of 1 to word 0 bit 3 clears it.
- R8: The interval counts while either enable is 1. Clearing just one enable does not stop it.
- R9: With both enables at 0, the interval counter is cleared and held, and no expiry occurs. A later start always times a full interval.
- R10: With ENABLE_ONCE set, once an enable has been 1, writes cannot clear either enable and the watchdog keeps expiring.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for timebase, interval and registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | ADDR_W | Byte address of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | High while the first-expiry state flag is set |
| wdog_rst | output | 1 | Reset pulse on the second unserviced expiry |

## Verification
The main function is exercised with several start patterns:
- Started through enable 1 alone.
- Started through enable 2 alone.
- Started through both enables, then one dropped.

Each pattern is timed to the exact cycle, so an off-by-one interval or a counter gated by the wrong enable shows up. A periodic keepalive must hold `irq` low across several intervals. Unserviced operation must give `irq` first and then a pulse of the exact width, which separates the two expiry stages. A short start/stop/start sequence separates a counter that is cleared on stop from one that merely holds. A second, locked instance shows disable writes being ignored, read back through the status words and through its continued expiry.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;

    localparam int DATA_W = 32;

    // word slots decoded from address bits [3:2]
    localparam logic [1:0] SLOT_CTL0 = 2'd0;
    localparam logic [1:0] SLOT_CTL1 = 2'd1;
    localparam logic [1:0] SLOT_TB   = 2'd2;

    // bit positions inside the control/status words
    localparam int BIT_EN2  = 0;
    localparam int BIT_EN1  = 1;
    localparam int BIT_STAT = 2;
    localparam int BIT_RSTF = 3;

    typedef struct packed {
        logic lock;
        logic rst_flag;
        logic state_flag;
        logic en1;
        logic en2;
    } ctl_t;

endpackage

// File: rtl/wdt_timebase.sv
`timescale 1ns/1ps
module wdt_timebase #(
    parameter int TB_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TB_W-1:0] count
);

    logic [TB_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + {{(TB_W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/wdt_interval.sv
`timescale 1ns/1ps
module wdt_interval #(
    parameter int INTERVAL_LOG2 = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expire
);

    logic [INTERVAL_LOG2-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run || restart) cnt_d = '0;
        else                 cnt_d = cnt_q + {{(INTERVAL_LOG2-1){1'b0}}, 1'b1};
        expire = run && !restart && (cnt_q == {INTERVAL_LOG2{1'b1}});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/wdt_rst_pulse.sv
`timescale 1ns/1ps
module wdt_rst_pulse #(
    parameter int RST_W = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);

    localparam int CW = $clog2(RST_W + 1);

    logic [CW-1:0] left_d, left_q;

    always_comb begin
        if (fire)                left_d = CW'(RST_W);
        else if (left_q != '0)   left_d = left_q - {{(CW-1){1'b0}}, 1'b1};
        else                     left_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

    assign pulse = (left_q != '0);

endmodule

// File: rtl/wdt_regs.sv
`timescale 1ns/1ps
module wdt_regs
    import wdt_pkg::*;
#(
    parameter bit ENABLE_ONCE = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr0,
    input  logic       wr1,
    input  logic [3:0] wbits,
    input  logic       expire,
    output ctl_t       ctl,
    output logic       keepalive,
    output logic       fire
);

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d     = ctl_q;
        keepalive = wr0 && wbits[BIT_STAT];
        fire      = expire && ctl_q.state_flag;

        // enables: a locked enable can only be written to 1
        if (wr0) ctl_d.en1 = wbits[BIT_EN1] | (ctl_q.lock & ctl_q.en1);
        if (wr0 || wr1) ctl_d.en2 = wbits[BIT_EN2] | (ctl_q.lock & ctl_q.en2);

        // lock engages once the watchdog has been running
        ctl_d.lock = ctl_q.lock | (ENABLE_ONCE & (ctl_q.en1 | ctl_q.en2));

        // first stage: keepalive beats a coincident expiry
        if (keepalive)                         ctl_d.state_flag = 1'b0;
        else if (expire && !ctl_q.state_flag)  ctl_d.state_flag = 1'b1;

        // reset-status: a new event beats a coincident clear
        if (fire)                         ctl_d.rst_flag = 1'b1;
        else if (wr0 && wbits[BIT_RSTF])  ctl_d.rst_flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl = ctl_q;

endmodule

// File: rtl/dual_stage_wdog.sv
`timescale 1ns/1ps
module dual_stage_wdog
    import wdt_pkg::*;
#(
    parameter int ADDR_W        = 4,
    parameter int INTERVAL_LOG2 = 12,
    parameter int TB_W          = 32,
    parameter int RST_W         = 1,
    parameter bit ENABLE_ONCE   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              wdog_rst
);

    logic            hi_zero;
    logic [1:0]      slot;
    logic            wr0, wr1;
    logic [TB_W-1:0] tb_count;
    logic            expire, keepalive, fire, run;
    ctl_t            ctl;
    logic            en1, en2, state_flag, rst_flag;
    logic            unused_bits;

    generate
        if (ADDR_W > 4) begin : g_hi
            assign hi_zero = (bus_addr[ADDR_W-1:4] == '0);
        end else begin : g_nohi
            assign hi_zero = 1'b1;
        end
    endgenerate

    assign slot        = bus_addr[3:2];
    assign wr0         = bus_wr && hi_zero && (slot == SLOT_CTL0);
    assign wr1         = bus_wr && hi_zero && (slot == SLOT_CTL1);
    assign unused_bits = ^{bus_wdata[31:4], bus_addr[1:0]};

    wdt_timebase #(.TB_W(TB_W)) u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .count (tb_count)
    );

    wdt_regs #(.ENABLE_ONCE(ENABLE_ONCE)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr0       (wr0),
        .wr1       (wr1),
        .wbits     (bus_wdata[3:0]),
        .expire    (expire),
        .ctl       (ctl),
        .keepalive (keepalive),
        .fire      (fire)
    );

    assign en1        = ctl.en1;
    assign en2        = ctl.en2;
    assign state_flag = ctl.state_flag;
    assign rst_flag   = ctl.rst_flag;
    assign run        = en1 | en2;

    wdt_interval #(.INTERVAL_LOG2(INTERVAL_LOG2)) u_ivl (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (keepalive),
        .expire  (expire)
    );

    wdt_rst_pulse #(.RST_W(RST_W)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .pulse (wdog_rst)
    );

    assign irq = state_flag;

    always_comb begin
        bus_rdata = '0;
        if (hi_zero) begin
            case (slot)
                SLOT_CTL0: begin
                    bus_rdata[BIT_RSTF] = rst_flag;
                    bus_rdata[BIT_STAT] = state_flag;
                    bus_rdata[BIT_EN1]  = en1;
                    bus_rdata[BIT_EN2]  = en2;
                end
                SLOT_CTL1: bus_rdata[BIT_EN2] = en2;
                SLOT_TB:   bus_rdata = DATA_W'(tb_count);
                default:   bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/wdt_checker.sv
`timescale 1ns/1ps
module wdt_checker #(
    parameter int ADDR_W      = 4,
    parameter bit ENABLE_ONCE = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              irq,
    input logic              wdog_rst,
    input logic              en1,
    input logic              en2,
    input logic              rst_flag
);

    logic w0;
    assign w0 = bus_wr && (bus_addr[ADDR_W-1:2] == '0);

    a_r6_keepalive_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (w0 && bus_wdata[2]) |=> !irq);

    a_r5_pulse_after_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdog_rst) |-> irq);

    a_r5_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdog_rst) |-> rst_flag);

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_flag && !(w0 && bus_wdata[3])) |=> rst_flag);

    a_r9_idle_no_new_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!en1 && !en2) |=> !$rose(irq));

    a_r10_lock_en1: assert property (@(posedge clk) disable iff (!rst_n)
        (ENABLE_ONCE && en1) |=> en1);

    a_r10_lock_en2: assert property (@(posedge clk) disable iff (!rst_n)
        (ENABLE_ONCE && en2) |=> en2);

endmodule

bind dual_stage_wdog wdt_checker #(
    .ADDR_W      (ADDR_W),
    .ENABLE_ONCE (ENABLE_ONCE)
) u_wdt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .wdog_rst  (wdog_rst),
    .en1       (en1),
    .en2       (en2),
    .rst_flag  (rst_flag)
);

// File: tb/dual_stage_wdog_bench.sv
`timescale 1ns/1ps
module dual_stage_wdog_bench;

    localparam int N   = 5;
    localparam int IVL = 1 << N;
    localparam int RW  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic        m_wr = 1'b0, l_wr = 1'b0;
    logic [3:0]  m_addr = '0, l_addr = '0;
    logic [31:0] m_wdata = '0, l_wdata = '0;
    logic [31:0] m_rdata, l_rdata;
    logic        m_irq, l_irq, m_rst, l_rst;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_stage_wdog #(.ADDR_W(4), .INTERVAL_LOG2(N), .TB_W(32), .RST_W(RW), .ENABLE_ONCE(1'b0))
    u_dual_stage_wdog (
        .clk(clk), .rst_n(rst_n), .bus_wr(m_wr), .bus_addr(m_addr), .bus_wdata(m_wdata),
        .bus_rdata(m_rdata), .irq(m_irq), .wdog_rst(m_rst)
    );

    dual_stage_wdog #(.ADDR_W(4), .INTERVAL_LOG2(N), .TB_W(32), .RST_W(RW), .ENABLE_ONCE(1'b1))
    u_dual_stage_wdog_lock (
        .clk(clk), .rst_n(rst_n), .bus_wr(l_wr), .bus_addr(l_addr), .bus_wdata(l_wdata),
        .bus_rdata(l_rdata), .irq(l_irq), .wdog_rst(l_rst)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit lk, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        if (lk) begin l_wr = 1'b1; l_addr = a; l_wdata = d; end
        else    begin m_wr = 1'b1; m_addr = a; m_wdata = d; end
        @(negedge clk);
        l_wr = 1'b0; m_wr = 1'b0;
    endtask

    task automatic rd(input bit lk, input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        if (lk) l_addr = a; else m_addr = a;
        #1;
        v = lk ? l_rdata : m_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq", {31'b0, m_irq}, 32'd0);
        check("R1 wdog_rst", {31'b0, m_rst}, 32'd0);
        rd(0, 4'h0, v); check("R1 word0", v, 32'd0);
        rd(0, 4'h4, v); check("R1 word1", v, 32'd0);
    endtask

    task automatic t_timebase();
        logic [31:0] a, b, v;
        rd(0, 4'h8, a);
        rd(0, 4'h8, b);
        check("R3 timebase step", b - a, 32'd1);
        rd(0, 4'hC, v); check("R2 unmapped read", v, 32'd0);
    endtask

    task automatic t_two_stage();
        logic [31:0] v;
        wr(0, 4'h0, 32'hE);                       // clear flags, enable 1
        cyc(IVL - 1); check("R4 irq before interval", {31'b0, m_irq}, 32'd0);
        cyc(1);       check("R4 irq at interval", {31'b0, m_irq}, 32'd1);
        cyc(IVL - 1); check("R5 no pulse early", {31'b0, m_rst}, 32'd0);
        for (int i = 0; i < RW; i++) begin
            cyc(1); check("R5 pulse high", {31'b0, m_rst}, 32'd1);
        end
        cyc(1); check("R5 pulse width end", {31'b0, m_rst}, 32'd0);
        rd(0, 4'h0, v); check("R2 R5 word0 flags", v, 32'hE);
    endtask

    task automatic t_keepalive();
        logic [31:0] v;
        wr(0, 4'h0, 32'h6);                       // keepalive, keep enable 1
        check("R6 irq cleared", {31'b0, m_irq}, 32'd0);
        rd(0, 4'h0, v); check("R7 flag kept on keepalive", v, 32'hA);
        for (int k = 0; k < 4; k++) begin
            for (int c = 0; c < IVL - 8; c++) begin
                cyc(1);
                if (m_irq !== 1'b0 || m_rst !== 1'b0) check("R6 serviced stays quiet", {30'b0, m_irq, m_rst}, 32'd0);
            end
            wr(0, 4'h0, 32'h6);
        end
        check("R6 no irq while serviced", {31'b0, m_irq}, 32'd0);
        wr(0, 4'h0, 32'h4);                       // stop, keep reset-status
        rd(0, 4'h0, v); check("R7 flag kept after stop", v, 32'h8);
        wr(0, 4'h0, 32'h8);
        rd(0, 4'h0, v); check("R7 flag cleared by W1C", v, 32'h0);
    endtask

    task automatic t_enables();
        logic [31:0] v;
        wr(0, 4'h4, 32'h1);                       // enable 2 alone
        cyc(IVL - 1); check("R8 en2 alone early", {31'b0, m_irq}, 32'd0);
        cyc(1);       check("R8 en2 alone expires", {31'b0, m_irq}, 32'd1);
        wr(0, 4'h0, 32'h7);                       // both on, keepalive
        wr(0, 4'h0, 32'h5);                       // drop enable 1 only
        cyc(IVL - 1); check("R8 one enable dropped early", {31'b0, m_irq}, 32'd0);
        cyc(1);       check("R8 still running", {31'b0, m_irq}, 32'd1);
        rd(0, 4'h0, v); check("R2 word0 en2 only", v, 32'h5);
        wr(0, 4'h0, 32'h4);                       // both off via word0 bit 0
        rd(0, 4'h4, v); check("R2 word0 bit0 clears en2", v, 32'h0);
        for (int c = 0; c < 3 * IVL; c++) begin
            cyc(1);
            if (m_irq !== 1'b0 || m_rst !== 1'b0) check("R9 stopped stays quiet", {30'b0, m_irq, m_rst}, 32'd0);
        end
        check("R9 no expiry when stopped", {31'b0, m_irq}, 32'd0);
        wr(0, 4'h4, 32'h1);
        cyc(10);
        wr(0, 4'h4, 32'h0);
        cyc(5);
        wr(0, 4'h4, 32'h1);
        cyc(IVL - 1); check("R9 counter cleared on stop", {31'b0, m_irq}, 32'd0);
        cyc(1);       check("R9 full interval after restart", {31'b0, m_irq}, 32'd1);
        wr(0, 4'h0, 32'h4);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        rd(1, 4'h0, v); check("R1 locked part reset", v, 32'h0);
        wr(1, 4'h0, 32'h2);
        wr(1, 4'h4, 32'h1);
        wr(1, 4'h0, 32'h4);                       // try to clear both enables
        rd(1, 4'h0, v); check("R10 word0 enables held", v, 32'h3);
        wr(1, 4'h4, 32'h0);
        rd(1, 4'h4, v); check("R10 word1 enable held", v, 32'h1);
        wr(1, 4'h0, 32'h0 | 32'h4);
        cyc(IVL - 1); check("R10 locked early", {31'b0, l_irq}, 32'd0);
        cyc(1);       check("R10 locked still expires", {31'b0, l_irq}, 32'd1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_timebase();
        t_two_stage();
        t_keepalive();
        t_enables();
        t_lock();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule